// File: doc/BRIEF.md
# Interval Activity Monitor

This block gathers usage statistics for a memory controller with several pseudo channels. Every clock cycle it samples one strobe per pseudo channel for each command kind: plain read, read with auto-precharge, plain write, write with auto-precharge, activate, single-bank precharge, all-bank precharge and refresh. It also samples two level inputs that show the memory sitting in power-down or in self-refresh. Over a programmed number of clock cycles it counts commands, read-to-write turnarounds, and cycles spent in each low-power state.

When the interval closes, the working counts are copied into snapshot outputs, and those outputs hold until the next interval closes. A completion flag rises at the same time. Software polls the flag, and reading the flag as 1 clears it. There are two ways to run the monitor. In repeat mode it starts as soon as the repeat control is high and runs intervals back to back. In single mode it runs exactly one interval for each start pulse.

Top module: `activity_monitor`

## Requirements
- R1: After reset every snapshot output is 0, `done_flag` is 0, and no interval is running.
- R2: An interval covers exactly `cfg_ivl_len` clock cycles, starting with the cycle after the one in which the start is sampled. Events in the start cycle or outside the interval are not counted. A length of 0 behaves as a length of 1.
- R3: With `cfg_repeat` low, a one-cycle pulse on `start_once` runs one interval and the monitor then stops. A `start_once` pulse that arrives while an interval is running is ignored.
- R4: While `cfg_repeat` is high, an idle monitor starts, and each interval is followed at once by the next with no gap cycle. If `cfg_repeat` is low at the end of an interval, that interval completes and no new one begins.
- R5: The snapshots change only at the end of an interval. They then take the counts including the final cycle, are visible from the next cycle, and hold until the next interval ends.
- R6: `snap_cmd` holds NUM_EV=9 fields of CNT_W bits for each pseudo channel. Field `f` of channel `p` sits at bit offset `(p*9+f)*CNT_W`. The field order is: 0 read, 1 read with auto-precharge, 2 write, 3 write with auto-precharge, 4 activate, 5 precharge, 6 precharge-all, 7 refresh, 8 turnaround. Each field counts only its own strobe.
- R7: Field 8 counts the write commands (plain or auto-precharge) whose most recent earlier read-or-write command on the same channel was a read. Idle cycles between the two do not matter, and this command history carries across intervals and idle time. When a read and a write arrive in the same cycle, the write is compared with the earlier history and the read then becomes the latest command.
- R8: `snap_pwr_down` and `snap_self_ref` count the cycles of the interval in which `lvl_pwr_down` or `lvl_self_ref` is high.
- R9: Each count saturates at 2^CNT_W-1.
- R10: `done_flag` goes high in the cycle after an interval ends. It clears in the cycle after `done_read` is sampled high while the flag is 1. If a new interval ends in that same cycle, the flag stays set.
- R11: Each interval starts from zero counts. Nothing carries over from the previous interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ivl_len | input | IVL_W | Interval length in cycles (0 means 1) |
| cfg_repeat | input | 1 | Repeat mode: start and keep restarting |
| start_once | input | 1 | Start pulse for a single interval |
| ev_rd | input | NUM_PC | Plain read strobe per channel |
| ev_rd_ap | input | NUM_PC | Read with auto-precharge strobe |
| ev_wr | input | NUM_PC | Plain write strobe |
| ev_wr_ap | input | NUM_PC | Write with auto-precharge strobe |
| ev_act | input | NUM_PC | Activate strobe |
| ev_pre | input | NUM_PC | Single-bank precharge strobe |
| ev_pre_all | input | NUM_PC | All-bank precharge strobe |
| ev_refresh | input | NUM_PC | Refresh strobe |
| lvl_pwr_down | input | 1 | Memory is in power-down this cycle |
| lvl_self_ref | input | 1 | Memory is in self-refresh this cycle |
| done_read | input | 1 | Completion flag is being read |
| done_flag | output | 1 | Interval completed |
| snap_cmd | output | NUM_PC*9*CNT_W | Per-channel command snapshots |
| snap_pwr_down | output | CNT_W | Power-down cycle snapshot |
| snap_self_ref | output | CNT_W | Self-refresh cycle snapshot |

## Verification
Counting timing is fixed by the start: the start is sampled at one edge, events are counted at the next `cfg_ivl_len` edges, and the snapshots and `done_flag` change at the last of those edges. The bench therefore checks all results at the falling edge right after that last counted edge. In repeat mode this falling edge already falls inside the next interval, so the check is made there, before that interval's stimulus is applied. Clearing by `done_read` takes effect one edge after the read, and the bench checks it at the following falling edge. Stopping is confirmed by holding events active for several further cycles and then finding the snapshots and flag unchanged.

// File: rtl/am_pkg.sv
package am_pkg;
  // field index of each counted event inside one pseudo channel's group
  localparam int EV_RD    = 0;
  localparam int EV_RDAP  = 1;
  localparam int EV_WR    = 2;
  localparam int EV_WRAP  = 3;
  localparam int EV_ACT   = 4;
  localparam int EV_PRE   = 5;
  localparam int EV_PREA  = 6;
  localparam int EV_REF   = 7;
  localparam int EV_TURN  = 8;
  localparam int NUM_EV   = 9;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/am_timer.sv
module am_timer import am_pkg::*; #(
  parameter int IVL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IVL_W-1:0] ivl_len,
  input  logic             repeat_en,
  input  logic             single_start,
  output logic             run_o,
  output logic             clr_o,
  output logic             last_o
);
  seq_state_t       st_q, st_d;
  logic [IVL_W-1:0] tmr_q, tmr_d;
  logic [IVL_W-1:0] len_eff;
  logic             start;
  logic             last;

  always_comb begin
    len_eff = (ivl_len == '0) ? {{(IVL_W-1){1'b0}}, 1'b1} : ivl_len;
    start   = (st_q == SEQ_IDLE) && (repeat_en || single_start);
    last    = (st_q == SEQ_RUN) && (tmr_q >= len_eff - 1'b1);
    st_d    = st_q;
    tmr_d   = tmr_q;
    if (start) begin
      st_d  = SEQ_RUN;
      tmr_d = '0;
    end else if (last) begin
      st_d  = repeat_en ? SEQ_RUN : SEQ_IDLE;
      tmr_d = '0;
    end else if (st_q == SEQ_RUN) begin
      tmr_d = tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  assign run_o  = (st_q == SEQ_RUN);
  assign clr_o  = start || last;
  assign last_o = last;

  AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !repeat_en) |=> (st_q == SEQ_IDLE)); // R3
  AST_REPEAT_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (last && repeat_en) |=> (st_q == SEQ_RUN && tmr_q == '0)); // R4
  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SEQ_IDLE) && repeat_en) |=> (st_q == SEQ_RUN)); // R4
endmodule

// File: rtl/am_counter.sv
module am_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             inc,
  input  logic             clr,
  input  logic             snap_en,
  output logic [CNT_W-1:0] snap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_upd;
  logic [CNT_W-1:0] snap_q, snap_d;

  always_comb begin
    cnt_upd = cnt_q;
    if (count_en && inc && (cnt_q != CNT_MAX)) cnt_upd = cnt_q + 1'b1;
    cnt_d  = clr ? '0 : cnt_upd;
    snap_d = snap_en ? cnt_upd : snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      snap_q <= snap_d;
    end
  end

  assign snap_o = snap_q;

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_en |=> $stable(snap_q)); // R5
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX)); // R9
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q >= $past(cnt_q))); // R9
endmodule

// File: rtl/am_turn.sv
module am_turn (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_any,
  input  logic wr_any,
  output logic turn_o
);
  logic last_rd_q, last_rd_d;

  always_comb begin
    last_rd_d = last_rd_q;
    if (rd_any)      last_rd_d = 1'b1;
    else if (wr_any) last_rd_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_rd_q <= 1'b0;
    else        last_rd_q <= last_rd_d;
  end

  assign turn_o = wr_any && last_rd_q;

  AST_WR_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !rd_any) |=> !turn_o); // R7
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> (wr_any == turn_o)); // R7
endmodule

// File: rtl/activity_monitor.sv
module activity_monitor import am_pkg::*; #(
  parameter int NUM_PC = 2,
  parameter int CNT_W  = 32,
  parameter int IVL_W  = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IVL_W-1:0]            cfg_ivl_len,
  input  logic                        cfg_repeat,
  input  logic                        start_once,
  input  logic [NUM_PC-1:0]           ev_rd,
  input  logic [NUM_PC-1:0]           ev_rd_ap,
  input  logic [NUM_PC-1:0]           ev_wr,
  input  logic [NUM_PC-1:0]           ev_wr_ap,
  input  logic [NUM_PC-1:0]           ev_act,
  input  logic [NUM_PC-1:0]           ev_pre,
  input  logic [NUM_PC-1:0]           ev_pre_all,
  input  logic [NUM_PC-1:0]           ev_refresh,
  input  logic                        lvl_pwr_down,
  input  logic                        lvl_self_ref,
  input  logic                        done_read,
  output logic                        done_flag,
  output logic [NUM_PC*NUM_EV*CNT_W-1:0] snap_cmd,
  output logic [CNT_W-1:0]            snap_pwr_down,
  output logic [CNT_W-1:0]            snap_self_ref
);
  localparam int GRP_W = NUM_EV * CNT_W;

  logic run, clr, last;
  logic done_q, done_d;

  am_timer #(.IVL_W(IVL_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .ivl_len      (cfg_ivl_len),
    .repeat_en    (cfg_repeat),
    .single_start (start_once),
    .run_o        (run),
    .clr_o        (clr),
    .last_o       (last)
  );

  for (genvar p = 0; p < NUM_PC; p++) begin : g_pc
    logic [NUM_EV-1:0] ev_vec;
    logic              turn;

    am_turn u_turn (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_any (ev_rd[p] | ev_rd_ap[p]),
      .wr_any (ev_wr[p] | ev_wr_ap[p]),
      .turn_o (turn)
    );

    assign ev_vec[EV_RD]   = ev_rd[p];
    assign ev_vec[EV_RDAP] = ev_rd_ap[p];
    assign ev_vec[EV_WR]   = ev_wr[p];
    assign ev_vec[EV_WRAP] = ev_wr_ap[p];
    assign ev_vec[EV_ACT]  = ev_act[p];
    assign ev_vec[EV_PRE]  = ev_pre[p];
    assign ev_vec[EV_PREA] = ev_pre_all[p];
    assign ev_vec[EV_REF]  = ev_refresh[p];
    assign ev_vec[EV_TURN] = turn;

    for (genvar f = 0; f < NUM_EV; f++) begin : g_ev
      am_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (run),
        .inc      (ev_vec[f]),
        .clr      (clr),
        .snap_en  (last),
        .snap_o   (snap_cmd[p*GRP_W + f*CNT_W +: CNT_W])
      );
    end
  end

  am_counter #(.CNT_W(CNT_W)) u_cnt_pd (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (run),
    .inc      (lvl_pwr_down),
    .clr      (clr),
    .snap_en  (last),
    .snap_o   (snap_pwr_down)
  );

  am_counter #(.CNT_W(CNT_W)) u_cnt_sr (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (run),
    .inc      (lvl_self_ref),
    .clr      (clr),
    .snap_en  (last),
    .snap_o   (snap_self_ref)
  );

  always_comb begin
    done_d = done_q;
    if (last)                   done_d = 1'b1;
    else if (done_read && done_q) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign done_flag = done_q;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done_flag); // R10
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !done_read) |=> done_flag); // R10
  AST_FLAG_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_flag && !last) |=> !done_flag); // R10
endmodule

// File: tb/activity_monitor_test.sv
module activity_monitor_test;
  localparam int NPC  = 2;
  localparam int CW   = 4;
  localparam int IW   = 8;
  localparam int NEV  = 9;
  localparam int MAXC = 15;

  logic clk = 1'b0;
  logic rst_n;
  logic [IW-1:0] ivl;
  logic rep, sgl, frd;
  logic [NPC-1:0] rd, rdap, wr, wrap, act, pre, prea, rf;
  logic pd, sr;
  logic done;
  logic [NPC*NEV*CW-1:0] snap_cmd;
  logic [CW-1:0] snap_pd, snap_sr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int  w [NPC][NEV];
  int  e [NPC][NEV];
  int  wpd, wsr, epd, esr;
  bit  lrd [NPC];
  bit  pend = 0;
  string ptag = "";

  activity_monitor #(.NUM_PC(NPC), .CNT_W(CW), .IVL_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_ivl_len(ivl), .cfg_repeat(rep),
    .start_once(sgl), .ev_rd(rd), .ev_rd_ap(rdap), .ev_wr(wr),
    .ev_wr_ap(wrap), .ev_act(act), .ev_pre(pre), .ev_pre_all(prea),
    .ev_refresh(rf), .lvl_pwr_down(pd), .lvl_self_ref(sr),
    .done_read(frd), .done_flag(done), .snap_cmd(snap_cmd),
    .snap_pwr_down(snap_pd), .snap_self_ref(snap_sr)
  );

  always #4 clk = ~clk;

  function automatic int sat(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  task automatic chk(input string req, input int act_v, input int exp_v, input string what);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
    end
  endtask

  function automatic bit pat(input int k, input int p, input int f, input int seed, input int dens);
    return ((k*5 + p*3 + f*7 + seed) % dens) == 0;
  endfunction

  task automatic drive_ev(input int k, input int seed, input int dens);
    for (int p = 0; p < NPC; p++) begin
      rd[p]   = pat(k, p, 0, seed, dens);
      rdap[p] = pat(k, p, 1, seed, dens);
      wr[p]   = pat(k, p, 2, seed, dens);
      wrap[p] = pat(k, p, 3, seed, dens);
      act[p]  = pat(k, p, 4, seed, dens);
      pre[p]  = pat(k, p, 5, seed, dens);
      prea[p] = pat(k, p, 6, seed, dens);
      rf[p]   = pat(k, p, 7, seed, dens);
    end
    pd = (dens == 1) || (((k + seed) % 3) != 0);
    sr = (dens == 1) || (((k + seed) % 5) == 0);
  endtask

  task automatic quiet();
    rd = '0; rdap = '0; wr = '0; wrap = '0; act = '0; pre = '0; prea = '0; rf = '0;
    pd = 1'b0; sr = 1'b0;
  endtask

  // one clock edge; model follows the stated requirements
  task automatic tick(input bit inwin);
    bit b [8];
    bit ra, wa;
    @(posedge clk);
    for (int p = 0; p < NPC; p++) begin
      b[0] = rd[p]; b[1] = rdap[p]; b[2] = wr[p]; b[3] = wrap[p];
      b[4] = act[p]; b[5] = pre[p]; b[6] = prea[p]; b[7] = rf[p];
      ra = rd[p] | rdap[p];
      wa = wr[p] | wrap[p];
      if (inwin) begin
        for (int f = 0; f < 8; f++) if (b[f]) w[p][f] = sat(w[p][f] + 1);
        if (wa && lrd[p]) w[p][8] = sat(w[p][8] + 1);          // R7
      end
      if (ra) lrd[p] = 1'b1;
      else if (wa) lrd[p] = 1'b0;
    end
    if (inwin) begin
      if (pd) wpd = sat(wpd + 1);
      if (sr) wsr = sat(wsr + 1);
    end
  endtask

  task automatic check_all(input string tag, input bit flag_exp);
    for (int p = 0; p < NPC; p++)
      for (int f = 0; f < NEV; f++)
        chk((f == 8) ? "R7" : "R6", int'(snap_cmd[(p*NEV+f)*CW +: CW]), e[p][f],
            $sformatf("%s pc%0d field%0d", tag, p, f));
    chk("R8", int'(snap_pd), epd, {tag, " power-down"});
    chk("R8", int'(snap_sr), esr, {tag, " self-refresh"});
    chk("R10", int'(done), int'(flag_exp), {tag, " done flag"});
  endtask

  task automatic one_window(input int len, input int seed, input int dens,
                            input bit inj, input bit drop, input string tag);
    int n;
    n = (len == 0) ? 1 : len;
    for (int p = 0; p < NPC; p++) for (int f = 0; f < NEV; f++) w[p][f] = 0;   // R11
    wpd = 0; wsr = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 0 && pend) begin
        check_all(ptag, 1'b1);
        pend = 0;
      end
      if (k == 0 && drop) rep = 1'b0;
      sgl = inj && (k == 1);                                    // R3 ignored pulse
      drive_ev(k, seed, dens);
      tick(1'b1);
    end
    for (int p = 0; p < NPC; p++) for (int f = 0; f < NEV; f++) e[p][f] = w[p][f];
    epd = wpd; esr = wsr;
    pend = 1; ptag = tag;
  endtask

  task automatic flush_and_clear();
    @(negedge clk);
    quiet(); sgl = 1'b0;
    if (pend) begin check_all(ptag, 1'b1); pend = 0; end
    frd = 1'b1;
    tick(1'b0);
    @(negedge clk);
    frd = 1'b0;
    chk("R10", int'(done), 0, "flag cleared by read");
  endtask

  task automatic single_run(input int len, input int seed, input int dens, input bit inj, input string tag);
    @(negedge clk);
    rep = 1'b0; ivl = IW'(len); sgl = 1'b1;
    drive_ev(99, seed, dens);                                  // start-cycle events: R2
    tick(1'b0);
    one_window(len, seed, dens, inj, 1'b0, tag);
    flush_and_clear();
    // R3: stays stopped, events afterwards have no effect
    for (int k = 0; k < len + 3; k++) begin
      @(negedge clk); drive_ev(k, seed + 1, 2); tick(1'b0);
    end
    @(negedge clk); quiet();
    check_all({"R3 stopped after ", tag}, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ivl = '0; rep = 1'b0; sgl = 1'b0; frd = 1'b0;
    quiet();
    for (int p = 0; p < NPC; p++) begin
      lrd[p] = 1'b0;
      for (int f = 0; f < NEV; f++) begin w[p][f] = 0; e[p][f] = 0; end
    end
    wpd = 0; wsr = 0; epd = 0; esr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset", 1'b0);

    // R2/R3: single intervals over a sweep of lengths and patterns
    for (int len = 0; len <= 9; len++)
      for (int s = 0; s < 3; s++)
        single_run(len, s * 11 + len, 2 + s, 1'b0, $sformatf("R2 single len %0d seed %0d", len, s));

    // R3: start pulse while running is ignored
    single_run(6, 4, 3, 1'b1, "R3 start while running");

    // R9: saturation with every strobe active every cycle
    single_run(40, 0, 1, 1'b0, "R9 saturate");
    single_run(15, 0, 1, 1'b0, "R9 exact max");

    // R4/R5/R11: back-to-back repeating intervals, stop after repeat drops
    for (int len = 2; len <= 5; len++) begin
      @(negedge clk);
      rep = 1'b1; ivl = IW'(len);
      drive_ev(50, len, 2);
      tick(1'b0);
      for (int i = 0; i < 4; i++)
        one_window(len, len * 3 + i, 2 + (i % 3), 1'b0, i == 3,
                   $sformatf("R4 repeat len %0d pass %0d", len, i));
      flush_and_clear();
      for (int k = 0; k < len + 4; k++) begin
        @(negedge clk); drive_ev(k, 7, 2); tick(1'b0);
      end
      @(negedge clk); quiet();
      check_all($sformatf("R5 held after repeat stop len %0d", len), 1'b0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule